// File: doc/BRIEF.md
# Bank Capture and Address Decoder for a 24-bit Multiplexed-Bus Processor

This block is the glue between a processor that puts its upper address byte (the bank) on the data bus during the low clock phase and the memory and IO devices behind it. During the low phase it captures that bank byte and joins it to the 16-bit low address, giving a 24-bit address. In the high phase it keeps the captured bank, whatever the data bus then carries.

From the full address it drives four active-low chip selects: low RAM, an IO window, an EEPROM and banked high RAM. Every select requires the high clock phase and at least one of the two valid-address flags. As a result, no device is selected while the bus still carries the bank byte, or in an idle cycle.

The block also makes the read output enable, the write enable and the controls of the bidirectional data buffer. Writes to the EEPROM region are blocked unless a configuration input allows them.

Top module: `bankdec_top`

## Requirements
- R1: While `phi2` is low, `full_addr[23:16]` equals `bus_in` and `full_addr[15:0]` equals `addr_lo`, with no clock delay.
- R2: While `phi2` is high, `full_addr[23:16]` holds the `bus_in` value sampled at the last `clk` rising edge at which `phi2` was low. Changes on `bus_in` during the high phase have no effect.
- R3: `bank_zero` is 1 exactly when the current bank byte (as seen on `full_addr[23:16]`) is 0x00.
- R4: `cs_lowram_n` is low only when `phi2`=1, (`vda` or `vpa`)=1, the bank is 0 and `addr_lo` is in 0x0000–0x7FFF.
- R5: `cs_io_n` is low only when `phi2`=1, (`vda` or `vpa`)=1, the bank is 0 and `addr_lo` is in 0x8000–0xBFFF.
- R6: `cs_rom_n` is low only when `phi2`=1, (`vda` or `vpa`)=1, the bank is 0 and `addr_lo` is in 0xC000–0xFFFF. It never goes low for any other address, including the low phase.
- R7: `cs_hiram_n` is low only when `phi2`=1, (`vda` or `vpa`)=1 and the bank is non-zero, for any `addr_lo`.
- R8: When `phi2`=0, or when `vda`=`vpa`=0, all four selects are high. At most one select is low at any time.
- R9: `oe_n` equals NOT(`phi2` AND `rwb`). It is never low together with `we_n`.
- R10: `we_n` is low only when `phi2`=1, `rwb`=0 and (`vda` or `vpa`)=1. In the EEPROM region (bank 0, 0xC000–0xFFFF) it stays high unless `rom_wr_allow`=1.
- R11: `buf_en_n` is low exactly when `phi2`=1. `buf_dir` equals `rwb` (1 = drive toward the processor, 0 = toward memory).
- R12: After reset, and until a low phase has been sampled, the held bank is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, faster than `phi2` |
| rst_n | input | 1 | Active-low asynchronous reset |
| phi2 | input | 1 | Processor clock phase (1 = data phase) |
| rwb | input | 1 | 1 = read cycle, 0 = write cycle |
| vda | input | 1 | Valid data address flag |
| vpa | input | 1 | Valid program address flag |
| addr_lo | input | 16 | Low 16 address bits |
| bus_in | input | 8 | Shared data/bank bus as seen by the glue |
| rom_wr_allow | input | 1 | 1 = allow write strobes in the EEPROM region |
| full_addr | output | 24 | Bank byte joined with the low address |
| bank_zero | output | 1 | Current bank is 0x00 |
| cs_lowram_n | output | 1 | Low RAM select, active low |
| cs_io_n | output | 1 | IO window select, active low |
| cs_rom_n | output | 1 | EEPROM select, active low |
| cs_hiram_n | output | 1 | Banked RAM select, active low |
| oe_n | output | 1 | Read output enable, active low |
| we_n | output | 1 | Write enable, active low |
| buf_en_n | output | 1 | Data buffer enable, active low |
| buf_dir | output | 1 | Data buffer direction, 1 = toward processor |

## Verification
Bank capture and select decoding both act at the rising edge of `phi2`. In that same input step the bus switches from the bank byte to arbitrary data. The decoded select must therefore come from the held bank, not from the data now on the bus. The bench provokes this on every cycle. It changes `bus_in` to a random value, often one whose zero/non-zero status differs from the bank, exactly when `phi2` rises, and again later in the high phase. It then checks `full_addr`, `bank_zero` and each select against values computed from the bank the bench applied during the low phase.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;
   // index of each decoded region inside a select vector
   typedef enum logic [1:0] {
      RGN_LORAM = 2'd0,
      RGN_IO    = 2'd1,
      RGN_ROM   = 2'd2,
      RGN_HIRAM = 2'd3
   } region_e;

   localparam int NUM_RGN = 4;

   typedef struct packed {
      logic phase_hi;
      logic valid;
      logic read;
   } cyc_t;
endpackage

// File: rtl/bankdec_capture.sv
module bankdec_capture #(
   parameter int BANK_W      = 8,
   parameter bit TRANSPARENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic [BANK_W-1:0] bus_in,
   output logic [BANK_W-1:0] bank_out
);
   generate
      if (BANK_W < 1) begin : g_bad_w
         $error("BANK_W must be at least 1");
      end
   endgenerate

   logic [BANK_W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_q <= '0;
      else if (!phi2)
         held_q <= bus_in;
   end

   generate
      if (TRANSPARENT) begin : g_transparent
         assign bank_out = phi2 ? held_q : bus_in;
      end else begin : g_registered
         assign bank_out = held_q;
      end
   endgenerate

   // R2: nothing is loaded while the data phase is sampled
   p_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(phi2) |-> $stable(held_q));
endmodule

// File: rtl/bankdec_region.sv
module bankdec_region
   import bankdec_pkg::*;
#(
   parameter int          BANK_W   = 8,
   parameter int          LO_W     = 16,
   parameter logic [15:0] IO_BASE  = 16'h8000,
   parameter logic [15:0] ROM_BASE = 16'hC000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] bank,
   input  logic [LO_W-1:0]   addr_lo,
   input  logic              qualify,
   output logic [NUM_RGN-1:0] hit_raw,
   output logic [NUM_RGN-1:0] sel
);
   localparam logic [LO_W-1:0] IO_B  = LO_W'(IO_BASE);
   localparam logic [LO_W-1:0] ROM_B = LO_W'(ROM_BASE);

   generate
      if (IO_BASE >= ROM_BASE) begin : g_bad_order
         $error("IO_BASE must lie below ROM_BASE");
      end
      if (LO_W != 16) begin : g_bad_lo
         $error("LO_W must be 16 for the fixed window bases");
      end
   endgenerate

   logic bank_is_zero;
   assign bank_is_zero = (bank == '0);

   always_comb begin
      hit_raw            = '0;
      hit_raw[RGN_HIRAM] = !bank_is_zero;
      hit_raw[RGN_LORAM] = bank_is_zero && (addr_lo < IO_B);
      hit_raw[RGN_IO]    = bank_is_zero && (addr_lo >= IO_B) && (addr_lo < ROM_B);
      hit_raw[RGN_ROM]   = bank_is_zero && (addr_lo >= ROM_B);
   end

   genvar g;
   generate
      for (g = 0; g < NUM_RGN; g++) begin : g_qual
         assign sel[g] = hit_raw[g] && qualify;
      end
   endgenerate

   // R8: never two devices at once
   p_one_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
   // R6: EEPROM select strictly inside its window
   p_rom_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sel[RGN_ROM] |-> (bank == '0) && (addr_lo >= ROM_B));
endmodule

// File: rtl/bankdec_strobe.sv
module bankdec_strobe
   import bankdec_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  cyc_t cyc,
   input  logic rom_hit,
   input  logic rom_wr_allow,
   output logic oe_n,
   output logic we_n,
   output logic buf_en_n,
   output logic buf_dir
);
   logic wr_blocked;

   assign wr_blocked = rom_hit && !rom_wr_allow;
   assign oe_n       = !(cyc.phase_hi && cyc.read);
   assign we_n       = !(cyc.phase_hi && !cyc.read && cyc.valid && !wr_blocked);
   assign buf_en_n   = !cyc.phase_hi;
   assign buf_dir    = cyc.read;

   // R10: write strobe only in the data phase of a write
   p_we_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!buf_en_n && !buf_dir));
   // R9: read enable and write enable exclusive
   p_oe_we_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n));
endmodule

// File: rtl/bankdec_top.sv
module bankdec_top
   import bankdec_pkg::*;
#(
   parameter int          BANK_W      = 8,
   parameter int          LO_W        = 16,
   parameter logic [15:0] IO_BASE     = 16'h8000,
   parameter logic [15:0] ROM_BASE    = 16'hC000,
   parameter bit          TRANSPARENT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   phi2,
   input  logic                   rwb,
   input  logic                   vda,
   input  logic                   vpa,
   input  logic [LO_W-1:0]        addr_lo,
   input  logic [BANK_W-1:0]      bus_in,
   input  logic                   rom_wr_allow,
   output logic [BANK_W+LO_W-1:0] full_addr,
   output logic                   bank_zero,
   output logic                   cs_lowram_n,
   output logic                   cs_io_n,
   output logic                   cs_rom_n,
   output logic                   cs_hiram_n,
   output logic                   oe_n,
   output logic                   we_n,
   output logic                   buf_en_n,
   output logic                   buf_dir
);
   logic [BANK_W-1:0]  bank;
   logic [NUM_RGN-1:0] hit_raw;
   logic [NUM_RGN-1:0] sel;
   cyc_t               cyc;

   assign cyc.phase_hi = phi2;
   assign cyc.valid    = vda || vpa;
   assign cyc.read     = rwb;

   bankdec_capture #(.BANK_W(BANK_W), .TRANSPARENT(TRANSPARENT)) u_capture (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .bus_in(bus_in), .bank_out(bank)
   );

   bankdec_region #(
      .BANK_W(BANK_W), .LO_W(LO_W), .IO_BASE(IO_BASE), .ROM_BASE(ROM_BASE)
   ) u_region (
      .clk(clk), .rst_n(rst_n), .bank(bank), .addr_lo(addr_lo),
      .qualify(cyc.phase_hi && cyc.valid), .hit_raw(hit_raw), .sel(sel)
   );

   bankdec_strobe u_strobe (
      .clk(clk), .rst_n(rst_n), .cyc(cyc), .rom_hit(hit_raw[RGN_ROM]),
      .rom_wr_allow(rom_wr_allow), .oe_n(oe_n), .we_n(we_n),
      .buf_en_n(buf_en_n), .buf_dir(buf_dir)
   );

   assign full_addr   = {bank, addr_lo};
   assign bank_zero   = (bank == '0);
   assign cs_lowram_n = !sel[RGN_LORAM];
   assign cs_io_n     = !sel[RGN_IO];
   assign cs_rom_n    = !sel[RGN_ROM];
   assign cs_hiram_n  = !sel[RGN_HIRAM];

   // R8: no select outside a qualified data phase
   p_no_sel_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!phi2 || !(vda || vpa)) |-> (cs_lowram_n && cs_io_n && cs_rom_n && cs_hiram_n));
   // R10: EEPROM region write lock
   p_rom_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n && !rom_wr_allow) |-> !(bank_zero && (addr_lo >= LO_W'(ROM_BASE))));
endmodule

// File: tb/bankdec_top_tb.sv
`timescale 1ns/1ps
module bankdec_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        phi2 = 1'b1, rwb = 1'b1, vda = 1'b0, vpa = 1'b0, rom_wr_allow = 1'b0;
   logic [15:0] addr_lo = '0;
   logic [7:0]  bus_in = 8'h5A;
   logic [23:0] full_addr;
   logic        bank_zero, cs_lowram_n, cs_io_n, cs_rom_n, cs_hiram_n;
   logic        oe_n, we_n, buf_en_n, buf_dir;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   bankdec_top u_dut (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .rwb(rwb), .vda(vda), .vpa(vpa),
      .addr_lo(addr_lo), .bus_in(bus_in), .rom_wr_allow(rom_wr_allow),
      .full_addr(full_addr), .bank_zero(bank_zero), .cs_lowram_n(cs_lowram_n),
      .cs_io_n(cs_io_n), .cs_rom_n(cs_rom_n), .cs_hiram_n(cs_hiram_n),
      .oe_n(oe_n), .we_n(we_n), .buf_en_n(buf_en_n), .buf_dir(buf_dir)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // expected active-high selects {hiram, rom, io, lowram}
   function automatic logic [3:0] exp_sel(input logic [7:0] b, input logic [15:0] a,
                                          input logic ph, input logic v);
      logic [3:0] s;
      s = 4'b0000;
      if (ph && v) begin
         if (b != 8'h00)        s[3] = 1'b1;
         else if (a >= 16'hC000) s[2] = 1'b1;
         else if (a >= 16'h8000) s[1] = 1'b1;
         else                    s[0] = 1'b1;
      end
      return s;
   endfunction

   function automatic logic exp_we(input logic [7:0] b, input logic [15:0] a,
                                   input logic ph, input logic rw, input logic v,
                                   input logic cfg);
      logic in_rom;
      in_rom = (b == 8'h00) && (a >= 16'hC000);
      return !(ph && !rw && v && !(in_rom && !cfg));
   endfunction

   task automatic run_cycle(input logic [7:0] bnk, input logic [15:0] a, input logic [7:0] d,
                            input logic rw, input logic va, input logic pa, input logic cfg);
      logic [3:0] s;
      // low phase: bank on the bus
      @(negedge clk);
      phi2 = 1'b0; bus_in = bnk; addr_lo = a; rwb = rw; vda = va; vpa = pa; rom_wr_allow = cfg;
      #1;
      check("R1 addr low phase", full_addr, {bnk, a});
      check("R3 bank_zero low", bank_zero, bnk == 8'h00);
      check("R8 no select low", {cs_hiram_n, cs_rom_n, cs_io_n, cs_lowram_n}, 4'b1111);
      check("R9 oe low phase", oe_n, 1'b1);
      check("R10 we low phase", we_n, 1'b1);
      check("R11 buf off low", buf_en_n, 1'b1);
      // high phase: data replaces bank on the bus in the same step
      @(negedge clk);
      phi2 = 1'b1; bus_in = d;
      #1;
      s = exp_sel(bnk, a, 1'b1, va || pa);
      check("R2 bank held", full_addr, {bnk, a});
      check("R3 bank_zero high", bank_zero, bnk == 8'h00);
      check("R4 cs_lowram", cs_lowram_n, !s[0]);
      check("R5 cs_io", cs_io_n, !s[1]);
      check("R6 cs_rom", cs_rom_n, !s[2]);
      check("R7 cs_hiram", cs_hiram_n, !s[3]);
      check("R9 oe high", oe_n, !rw);
      check("R10 we high", we_n, exp_we(bnk, a, 1'b1, rw, va || pa, cfg));
      check("R11 buf on", {buf_en_n, buf_dir}, {1'b0, rw});
      // bus changes again later in the high phase
      @(negedge clk);
      bus_in = ~d;
      #1;
      check("R2 bank held late", full_addr[23:16], bnk);
      check("R6 cs_rom late", cs_rom_n, !s[2]);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'h1F2E);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R12 reset bank", full_addr[23:16], 8'h00);
      check("R12 reset bank_zero", bank_zero, 1'b1);
      check("R8 reset no select", {cs_hiram_n, cs_rom_n, cs_io_n, cs_lowram_n}, 4'b1111);

      // directed window boundaries, bank 0 reads
      run_cycle(8'h00, 16'h0000, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0);
      run_cycle(8'h00, 16'h7FFF, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0);
      run_cycle(8'h00, 16'h8000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
      run_cycle(8'h00, 16'hBFFF, 8'h80, 1'b1, 1'b1, 1'b1, 1'b0);
      run_cycle(8'h00, 16'hC000, 8'h55, 1'b1, 1'b0, 1'b1, 1'b0);
      run_cycle(8'h00, 16'hFFFF, 8'hAA, 1'b1, 1'b1, 1'b0, 1'b0);
      // non-zero banks with data bus reading zero in the data phase
      run_cycle(8'h01, 16'h0000, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
      run_cycle(8'hFF, 16'hFFFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
      // invalid cycle at an EEPROM address
      run_cycle(8'h00, 16'hE000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
      run_cycle(8'h00, 16'hE000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
      // EEPROM writes locked and allowed
      run_cycle(8'h00, 16'hF000, 8'h12, 1'b0, 1'b1, 1'b0, 1'b0);
      run_cycle(8'h00, 16'hF000, 8'h12, 1'b0, 1'b1, 1'b0, 1'b1);
      // writes elsewhere unaffected by the lock
      run_cycle(8'h00, 16'h1234, 8'h34, 1'b0, 1'b1, 1'b0, 1'b0);
      run_cycle(8'h00, 16'h9000, 8'h34, 1'b0, 1'b0, 1'b1, 1'b0);
      run_cycle(8'h42, 16'hC000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);

      for (int i = 0; i < 400; i++) begin
         logic [7:0]  b;
         logic [15:0] a;
         b = ($urandom % 2 == 0) ? 8'h00 : 8'($urandom);
         a = 16'($urandom);
         run_cycle(b, a, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule